// File: doc/BRIEF.md
# Load-Store Bus Response Integrity Checker

This block sits between a processor's load-store unit and a data bus whose words are 39 bits wide: 32 data bits and 7 check bits. Together the 39 bits form a single-error-correct, double-error-detect code. On the request side it forwards one access at a time. It computes the check bits for outgoing write data and records whether the access it issued was a load or a store. The record is held until that access's response arrives.

On the response side every returned word passes through a syndrome decoder. The decoder reports any non-zero syndrome and corrects single data-bit errors. The bus acknowledges stores with a response-valid pulse, but the payload of a store response is meaningless. For that reason the decoder's verdict counts only when the recorded direction is a load. A load error is reported on the cycle of the response and, one cycle later, raises a major alert. A store acknowledgement never produces an error or an alert, whatever bits it carries. The store-side error output exists for the consumer's interface but is held at zero, because no checker exists for store data.

Top module: `lsu_resp_intg`

## Requirements
- R1: While `rst_ni` is low and at the first edge after its release, `load_intg_err_o`, `alert_major_o`, `lsu_resp_valid_o` and `store_intg_err_o` are 0. No access is outstanding, so `bus_req_o` follows `req_valid_i`.
- R2: `bus_wdata_o[31:0]` equals `req_wdata_i`, and `bus_wdata_o[38:32]` is the check field `C ^ 7'h2A`. Data bit i is assigned column k_i, the i-th value (in ascending order, from 0) among the 7-bit values with exactly three ones. Bit j of `C` is the XOR of all data bits whose column has bit j set.
- R3: A response arriving while the outstanding access is a store (`bus_we_o` was 1 at its handshake) never raises `load_intg_err_o`, and never raises `alert_major_o` on the following cycle, for any payload.
- R4: On a load response whose word differs from a valid codeword in exactly one bit, `load_intg_err_o` is 1 in that cycle. If the bit is a data bit, `lsu_rdata_o` shows the corrected data.
- R5: On a load response with two flipped bits, `load_intg_err_o` is 1 in that cycle.
- R6: On a load response carrying a valid codeword, `load_intg_err_o` is 0 and `lsu_rdata_o` equals the data field.
- R7: `alert_major_o` is 1 in the cycle right after a cycle with `load_intg_err_o` high, and 0 after a cycle with it low.
- R8: Only one access is outstanding at a time. From the handshake (`req_valid_i` and `bus_gnt_i` with `bus_req_o` high) until its response, `bus_req_o` and `req_gnt_o` stay 0. A further request in that window leaves the recorded direction unchanged.
- R9: `bus_rvalid_i` with no outstanding access is ignored. `lsu_resp_valid_o` and `load_intg_err_o` stay 0, and no alert follows.
- R10: `store_intg_err_o` is 0 in every cycle.
- R11: An all-zero 39-bit word on a load response is flagged by `load_intg_err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| req_valid_i | input | 1 | Load-store unit requests an access |
| req_we_i | input | 1 | Access direction, 1 = store, 0 = load |
| req_wdata_i | input | 32 | Store data |
| req_gnt_o | output | 1 | Request accepted by the bus this cycle |
| bus_req_o | output | 1 | Request towards the bus |
| bus_we_o | output | 1 | Direction towards the bus |
| bus_wdata_o | output | 39 | Encoded store word |
| bus_gnt_i | input | 1 | Bus grant |
| bus_rvalid_i | input | 1 | Bus response valid (loads and stores) |
| bus_rdata_i | input | 39 | Returned word, don't-care on stores |
| lsu_resp_valid_o | output | 1 | Response for the outstanding access |
| lsu_rdata_o | output | 32 | Returned data after single-bit correction |
| load_intg_err_o | output | 1 | Integrity error on a load response |
| store_intg_err_o | output | 1 | Store response error, always 0 |
| alert_major_o | output | 1 | Registered major bus alert |

## Verification
The encoded write word, `lsu_resp_valid_o`, `lsu_rdata_o` and `load_intg_err_o` are combinational, so they are due in the same cycle as the stimulus that causes them. The only register in the alert path is the alert flop, which makes `alert_major_o` due exactly one cycle after the response. The bench drives inputs just after a rising edge and samples on the falling edge. The scoreboard pops one expected item at each falling edge where the response is valid. At the next falling edge it compares the alert against the error expected from the previous cycle. The one-outstanding window is probed on the cycle after each handshake.

// File: rtl/lsu_intg_pkg.sv
// Shared widths, code tables and check-bit arithmetic for the bus integrity code.
// Assumes a 32+7 Hsiao-style code with weight-3 columns and an inverted check field.
package lsu_intg_pkg;

    localparam int DATA_W = 32;
    localparam int CHK_W  = 7;
    localparam int WORD_W = DATA_W + CHK_W;

    // Fixed pattern XORed onto the check field so the all-zero word is not a codeword.
    localparam logic [CHK_W-1:0] INV_PAT = 7'h2A;

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [CHK_W-1:0]  chk_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [DATA_W-1:0][CHK_W-1:0] col_tab_t;

    // Columns: the weight-3 seven-bit values in ascending order, first DATA_W of them.
    function automatic col_tab_t build_cols();
        col_tab_t tab;
        int       n;
        tab = '0;
        n   = 0;
        for (int v = 0; v < (1 << CHK_W); v++) begin
            if ($countones(v[CHK_W-1:0]) == 3 && n < DATA_W) begin
                tab[n] = v[CHK_W-1:0];
                n++;
            end
        end
        return tab;
    endfunction

    localparam col_tab_t COLS = build_cols();

    // Raw (non-inverted) parity of the data bits selected by each check row.
    function automatic chk_t raw_check(data_t d);
        chk_t c;
        c = '0;
        for (int j = 0; j < CHK_W; j++) begin
            for (int i = 0; i < DATA_W; i++) begin
                if (COLS[i][j]) c[j] = c[j] ^ d[i];
            end
        end
        return c;
    endfunction

endpackage

// File: rtl/lsu_intg_enc.sv
// Check-bit encoder for outgoing store data.
// Assumes the code table of lsu_intg_pkg; purely combinational.
module lsu_intg_enc
    import lsu_intg_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CHK_W,
    localparam int WW = DW + CW
) (
    input  logic [DW-1:0] data_i,
    output logic [WW-1:0] word_o
);

    // Build the inverted check field and append it above the data.
    always_comb begin
        word_o = {raw_check(data_i) ^ INV_PAT, data_i};
    end

endmodule

// File: rtl/lsu_intg_dec.sv
// Syndrome decoder for returned bus words.
// Flags any non-zero syndrome; odd weight is treated as single, even as double.
// Corrects a data bit whose column matches the syndrome. Combinational.
module lsu_intg_dec
    import lsu_intg_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CHK_W,
    localparam int WW = DW + CW
) (
    input  logic [WW-1:0] word_i,
    output logic [DW-1:0] data_o,
    output logic [CW-1:0] syndrome_o,
    output logic          single_err_o,
    output logic          double_err_o
);

    logic [DW-1:0] data_raw;
    logic [CW-1:0] chk_raw;
    logic [DW-1:0] flip;

    assign data_raw = word_i[DW-1:0];
    assign chk_raw  = word_i[WW-1:DW];

    // Recompute the parity and compare with the received, de-inverted check field.
    always_comb begin
        syndrome_o = raw_check(data_raw) ^ chk_raw ^ INV_PAT;
    end

    // One correction comparator per data bit.
    for (genvar gi = 0; gi < DW; gi++) begin : g_fix
        assign flip[gi] = (syndrome_o == COLS[gi]);
    end

    // Apply the correction and classify the error by syndrome weight.
    always_comb begin
        data_o       = data_raw ^ flip;
        single_err_o = ^syndrome_o;
        double_err_o = (syndrome_o != '0) && !(^syndrome_o);
    end

endmodule

// File: rtl/lsu_dir_track.sv
// Outstanding-access tracker: one access at a time, records its direction.
// Assumes the response for an access never arrives in its own handshake cycle.
module lsu_dir_track (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic req_fire_i,
    input  logic req_we_i,
    input  logic resp_fire_i,
    output logic pending_o,
    output logic is_store_o
);

    logic pending_q;
    logic store_q;

    // Set on handshake, clear on the matching response.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pending_q <= 1'b0;
        end else if (req_fire_i) begin
            pending_q <= 1'b1;
        end else if (resp_fire_i) begin
            pending_q <= 1'b0;
        end
    end

    // Latch the direction only when a request handshake completes.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            store_q <= 1'b0;
        end else if (req_fire_i) begin
            store_q <= req_we_i;
        end
    end

    assign pending_o  = pending_q;
    assign is_store_o = store_q;

    // R8: no second handshake while an access is outstanding.
    a_r8_single_outstanding: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pending_q |-> !req_fire_i);

    // R8: direction held until the response returns.
    a_r8_dir_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pending_q && !resp_fire_i) |=> (pending_q && $stable(store_q)));

endmodule

// File: rtl/lsu_resp_intg.sv
// Top: request-side encoding and direction capture, response-side decoding
// with the error qualified by the recorded direction, and a registered major alert.
// Assumes one outstanding access; responses without an access are ignored.
module lsu_resp_intg
    import lsu_intg_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CHK_W,
    localparam int WW = DW + CW
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          req_valid_i,
    input  logic          req_we_i,
    input  logic [DW-1:0] req_wdata_i,
    output logic          req_gnt_o,
    output logic          bus_req_o,
    output logic          bus_we_o,
    output logic [WW-1:0] bus_wdata_o,
    input  logic          bus_gnt_i,
    input  logic          bus_rvalid_i,
    input  logic [WW-1:0] bus_rdata_i,
    output logic          lsu_resp_valid_o,
    output logic [DW-1:0] lsu_rdata_o,
    output logic          load_intg_err_o,
    output logic          store_intg_err_o,
    output logic          alert_major_o
);

    logic          pending;
    logic          is_store;
    logic          req_fire;
    logic          resp_fire;
    logic [CW-1:0] syndrome;
    logic          dec_single;
    logic          dec_double;
    logic          alert_q;

    // Forward a request only when nothing is outstanding.
    always_comb begin
        bus_req_o = req_valid_i && !pending;
        bus_we_o  = req_we_i;
        req_fire  = bus_req_o && bus_gnt_i;
        req_gnt_o = req_fire;
        resp_fire = bus_rvalid_i && pending;
    end

    lsu_dir_track i_track (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .req_fire_i  (req_fire),
        .req_we_i    (req_we_i),
        .resp_fire_i (resp_fire),
        .pending_o   (pending),
        .is_store_o  (is_store)
    );

    lsu_intg_enc #(.DW(DW), .CW(CW)) i_enc (
        .data_i (req_wdata_i),
        .word_o (bus_wdata_o)
    );

    lsu_intg_dec #(.DW(DW), .CW(CW)) i_dec (
        .word_i       (bus_rdata_i),
        .data_o       (lsu_rdata_o),
        .syndrome_o   (syndrome),
        .single_err_o (dec_single),
        .double_err_o (dec_double)
    );

    // Qualify the decoder verdict with the recorded direction; the store side has no checker.
    always_comb begin
        lsu_resp_valid_o = resp_fire;
        load_intg_err_o  = resp_fire && !is_store && (dec_single || dec_double);
        store_intg_err_o = 1'b0;
    end

    // Register the alert OR tree.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            alert_q <= 1'b0;
        end else begin
            alert_q <= load_intg_err_o;
        end
    end

    assign alert_major_o = alert_q;

    // R3: a store acknowledgement never yields an error.
    a_r3_store_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_rvalid_i && pending && is_store) |-> !load_intg_err_o);

    // R3: and never an alert on the next cycle.
    a_r3_store_no_alert: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_rvalid_i && pending && is_store) |=> !alert_major_o);

    // R4: any decoder error on a load response is reported.
    a_r4_load_flagged: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (resp_fire && !is_store && syndrome != '0) |-> load_intg_err_o);

    // R7: alert follows a load error by one cycle.
    a_r7_alert_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_intg_err_o |=> alert_major_o);

    // R9: a response with nothing outstanding is ignored.
    a_r9_unsolicited: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_rvalid_i && !pending) |-> (!lsu_resp_valid_o && !load_intg_err_o));

endmodule

// File: tb/test_lsu_resp_intg.sv
`timescale 1ns/1ps
module test_lsu_resp_intg;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_we = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        bus_gnt = 1'b0, bus_rvalid = 1'b0;
    logic [38:0] bus_rdata = '0;
    logic        req_gnt_o, bus_req_o, bus_we_o;
    logic [38:0] bus_wdata_o;
    logic        lsu_resp_valid_o, load_intg_err_o, store_intg_err_o, alert_major_o;
    logic [31:0] lsu_rdata_o;

    int total = 0;
    int bad = 0;

    typedef struct {
        bit          err;
        bit          chk_data;
        logic [31:0] data;
        string       tag;
    } exp_t;
    exp_t sb[$];
    bit exp_alert = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    lsu_resp_intg i_lsu_resp_intg (
        .clk_i(clk), .rst_ni(rst_n),
        .req_valid_i(req_valid), .req_we_i(req_we), .req_wdata_i(req_wdata),
        .req_gnt_o(req_gnt_o), .bus_req_o(bus_req_o), .bus_we_o(bus_we_o),
        .bus_wdata_o(bus_wdata_o), .bus_gnt_i(bus_gnt),
        .bus_rvalid_i(bus_rvalid), .bus_rdata_i(bus_rdata),
        .lsu_resp_valid_o(lsu_resp_valid_o), .lsu_rdata_o(lsu_rdata_o),
        .load_intg_err_o(load_intg_err_o), .store_intg_err_o(store_intg_err_o),
        .alert_major_o(alert_major_o)
    );

    task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Code per R2: weight-3 columns in ascending order, check field inverted by 2A.
    function automatic logic [6:0] col_of(int idx);
        int n = 0;
        for (int v = 0; v < 128; v++) begin
            if ($countones(v[6:0]) == 3) begin
                if (n == idx) return v[6:0];
                n++;
            end
        end
        return 7'h0;
    endfunction

    function automatic logic [38:0] encode(logic [31:0] d);
        logic [6:0] c = 7'h0;
        for (int i = 0; i < 32; i++) begin
            if (d[i]) c = c ^ col_of(i);
        end
        return {c ^ 7'h2A, d};
    endfunction

    // Monitor / scoreboard on the falling edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit nxt;
            nxt = 1'b0;
            check(alert_major_o == exp_alert, "R7 alert", alert_major_o, exp_alert);
            check(store_intg_err_o == 1'b0, "R10 store flag", store_intg_err_o, 0);
            if (lsu_resp_valid_o) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R9 unexpected response", 1, 0);
                end else begin
                    exp_t it;
                    it = sb.pop_front();
                    check(load_intg_err_o == it.err, it.tag, load_intg_err_o, it.err);
                    if (it.chk_data)
                        check(lsu_rdata_o == it.data, {it.tag, " data"}, lsu_rdata_o, it.data);
                    nxt = it.err;
                end
            end else begin
                check(load_intg_err_o == 1'b0, "R9 err without response", load_intg_err_o, 0);
            end
            exp_alert = nxt;
        end
    end

    // Driver: one full access, with a probe of the one-outstanding window.
    task automatic run_txn(bit we, logic [31:0] wd, logic [38:0] resp,
                           bit err, bit chk_data, logic [31:0] exp_d, string tag);
        exp_t it;
        @(posedge clk); #1;
        req_valid = 1'b1; req_we = we; req_wdata = wd; bus_gnt = 1'b1;
        @(negedge clk);
        check(bus_req_o == 1'b1, "R8 request forwarded", bus_req_o, 1);
        check(bus_wdata_o == encode(wd), "R2 encoded word", bus_wdata_o, encode(wd));
        check(bus_we_o == we, "R2 direction out", bus_we_o, we);
        @(posedge clk); #1;
        req_we = ~we;
        @(negedge clk);
        check({bus_req_o, req_gnt_o} == 2'b00, "R8 blocked while outstanding",
              {bus_req_o, req_gnt_o}, 0);
        @(posedge clk); #1;
        req_valid = 1'b0; bus_gnt = 1'b0;
        it.err = err; it.chk_data = chk_data; it.data = exp_d; it.tag = tag;
        sb.push_back(it);
        bus_rvalid = 1'b1; bus_rdata = resp;
        @(posedge clk); #1;
        bus_rvalid = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        check(1'b0, "watchdog", 0, 1);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [38:0] w;
        // R1: reset state.
        bus_rvalid = 1'b1; bus_rdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check({load_intg_err_o, alert_major_o, lsu_resp_valid_o, store_intg_err_o} == 4'b0,
              "R1 reset outputs", {load_intg_err_o, alert_major_o, lsu_resp_valid_o}, 0);
        @(posedge clk); #1;
        bus_rvalid = 1'b0; rst_n = 1'b1; req_valid = 1'b1;
        @(negedge clk);
        check(bus_req_o == 1'b1, "R1 idle after reset", bus_req_o, 1);
        check(alert_major_o == 1'b0, "R1 alert after reset", alert_major_o, 0);
        @(posedge clk); #1;
        req_valid = 1'b0;

        // R3: stores with junk payloads, including all-zero and all-one.
        run_txn(1'b1, 32'h0, 39'h0, 1'b0, 1'b0, 0, "R3 store zero payload");
        run_txn(1'b1, 32'hFFFF_FFFF, {39{1'b1}}, 1'b0, 1'b0, 0, "R3 store ones payload");
        for (int k = 0; k < 20; k++) begin
            d = $urandom;
            w = {$urandom, $urandom};
            run_txn(1'b1, d, w, 1'b0, 1'b0, 0, "R3 store junk payload");
        end

        // R6: clean loads.
        for (int k = 0; k < 8; k++) begin
            d = $urandom;
            run_txn(1'b0, 32'h0, encode(d), 1'b0, 1'b1, d, "R6 clean load");
        end

        // R4: single flips over every bit position.
        for (int b = 0; b < 39; b++) begin
            d = $urandom;
            w = encode(d);
            w[b] = ~w[b];
            run_txn(1'b0, 32'h0, w, 1'b1, 1'b1, d, "R4 single-bit load");
        end

        // R5: double flips.
        for (int k = 0; k < 12; k++) begin
            int b1, b2;
            d = $urandom;
            w = encode(d);
            b1 = $urandom_range(38, 0);
            b2 = (b1 + 1 + $urandom_range(37, 0)) % 39;
            w[b1] = ~w[b1];
            w[b2] = ~w[b2];
            run_txn(1'b0, 32'h0, w, 1'b1, 1'b0, 0, "R5 double-bit load");
        end

        // R11: all-zero word on a load.
        run_txn(1'b0, 32'h0, 39'h0, 1'b1, 1'b0, 0, "R11 all-zero load");

        // R3 after an erroring load: the store right after stays quiet.
        run_txn(1'b1, 32'h1234_5678, 39'h0, 1'b0, 1'b0, 0, "R3 store after error");

        // R9: unsolicited response with junk.
        @(posedge clk); #1;
        bus_rvalid = 1'b1; bus_rdata = 39'h0;
        @(negedge clk);
        check({lsu_resp_valid_o, load_intg_err_o} == 2'b00, "R9 unsolicited ignored",
              {lsu_resp_valid_o, load_intg_err_o}, 0);
        @(posedge clk); #1;
        bus_rvalid = 1'b0;

        repeat (4) @(posedge clk);
        @(negedge clk);
        check(sb.size() == 0, "R6 scoreboard drained", sb.size(), 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule